// File: doc/BRIEF.md
# Half-Iteration Soft-Value Combiner

Between two half-iterations of an iterative product-code decoder, the next stage needs a new soft input. That input is the channel observation for a symbol plus a weighted copy of the extrinsic value that the row or column soft-in/soft-out decoder produced for the same symbol. The extrinsic value is the decoder's soft output minus the soft input it received. The decoder needs a fixed number of cycles to produce it. This block keeps the channel values in a delay line of that same length, so that each channel value meets its own extrinsic value. It then scales the extrinsic value by a weight and adds the two with saturation. Each clock it handles a parameterised number of symbol lanes.

The weight changes from one half-iteration to the next. The caller gives a half-iteration index, and that index selects one entry of a 16-entry register table. Each entry holds an extrinsic weight and a second per-half-iteration constant. The second constant is only presented to the neighbouring decoder; the combiner does not use it. A simple write port loads the table. The decoding itself, the codeword memory and the iteration sequencing belong to other blocks. This block sees only the aligned symbol streams and a valid strobe.

Top module: `soft_combiner`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `out_soft` is all zeros. Every table entry resets to a weight of 8 (1.0) and a side constant of 0.
- R2: `out_valid` equals `in_valid` delayed by LAT+1 clock cycles.
- R3: Channel lane k presented with `in_valid` at cycle t combines with extrinsic lane k presented at cycle t+LAT. The result appears on `out_soft` at cycle t+LAT+1 and equals chan + scaled. Here scaled = (ext × w) / 8. The extrinsic value is signed EXT_W bits. The weight w is unsigned, with FRAC=3 fractional bits.
- R4: The scaled term is rounded toward zero. A negative product is never rounded toward minus infinity. For example, ext=-3 with w=3 gives -1, not -2.
- R5: The sum saturates to the symmetric range [-15, +15] of a 5-bit soft value and never wraps. A channel input of -16 with a zero weight yields -15.
- R6: Lanes are independent. Lane k occupies bits [k*SW +: SW] of the channel and output buses and bits [k*EXT_W +: EXT_W] of the extrinsic bus.
- R7: The weight used is the table entry addressed by `half_idx` in the cycle in which the extrinsic value is presented. The index is IDX_W=4 bits wide, so the table has 16 entries and the index wraps after entry 15.
- R8: When `wr_en` is high, `wr_alpha` and `wr_beta` are written into entry `wr_addr`. Reads see them from the next cycle on.
- R9: `beta_sel` shows, combinationally, the side constant of the entry addressed by `half_idx`.
- R10: While `out_valid` is 0, `out_soft` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Channel lanes valid |
| in_chan | input | LANES*SW | Channel soft values, signed, one per lane |
| ext_soft | input | LANES*EXT_W | Extrinsic values, LAT cycles after the matching channel values |
| half_idx | input | IDX_W | Current half-iteration index |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | IDX_W | Table entry to write |
| wr_alpha | input | WW | Extrinsic weight to write (unsigned, FRAC fractional bits) |
| wr_beta | input | BW | Side constant to write |
| beta_sel | output | BW | Side constant of the entry selected by half_idx |
| out_valid | output | 1 | Combined lanes valid |
| out_soft | output | LANES*SW | Combined, saturated soft values |

## Verification
The bench builds the block with two lanes and a delay of three cycles, and keeps the default widths. This makes an exhaustive sweep affordable. Every 5-bit channel value is paired with every 6-bit extrinsic value under every one of the 16 possible 4-bit weights. That sweep covers every rounding case for negative products and every saturation edge, including the -16 input. A short delay allows a different table entry to be selected on every cycle, and a stream with gaps shows the valid timing and how the output holds between valid cycles.

// File: rtl/soft_comb_pkg.sv
package soft_comb_pkg;

   // Legal parallelism factors for the lane array.
   function automatic bit lanes_legal(input int m);
      return (m == 1) || (m == 2) || (m == 4) || (m == 8);
   endfunction

   // Largest magnitude of a symmetric signed value of the given width.
   function automatic int sym_limit(input int width);
      return (1 << (width - 1)) - 1;
   endfunction

endpackage

// File: rtl/sc_delay_line.sv
module sc_delay_line #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [W-1:0] in_data,
   output logic         out_vld,
   output logic [W-1:0] out_data
);

   generate
      if (DEPTH == 0) begin : g_bypass
         assign out_vld  = in_vld;
         assign out_data = in_data;
      end else begin : g_shift
         logic [W-1:0] dat_q [DEPTH];
         logic [DEPTH-1:0] vld_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q <= '0;
               for (int i = 0; i < DEPTH; i++) dat_q[i] <= '0;
            end else begin
               vld_q[0] <= in_vld;
               dat_q[0] <= in_data;
               for (int i = 1; i < DEPTH; i++) begin
                  vld_q[i] <= vld_q[i-1];
                  dat_q[i] <= dat_q[i-1];
               end
            end
         end

         assign out_vld  = vld_q[DEPTH-1];
         assign out_data = dat_q[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/sc_weight_table.sv
module sc_weight_table #(
   parameter int IDX_W     = 4,
   parameter int WW        = 4,
   parameter int BW        = 4,
   parameter int ALPHA_RST = 8,
   parameter int BETA_RST  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [WW-1:0]    wr_alpha,
   input  logic [BW-1:0]    wr_beta,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [WW-1:0]    alpha_sel,
   output logic [BW-1:0]    beta_sel
);

   localparam int DEPTH = 1 << IDX_W;

   logic [WW-1:0] alpha_q [DEPTH];
   logic [BW-1:0] beta_q  [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            alpha_q[i] <= WW'(ALPHA_RST);
            beta_q[i]  <= BW'(BETA_RST);
         end
      end else if (wr_en) begin
         alpha_q[wr_addr] <= wr_alpha;
         beta_q[wr_addr]  <= wr_beta;
      end
   end

   assign alpha_sel = alpha_q[rd_idx];
   assign beta_sel  = beta_q[rd_idx];

   AST_TABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == rd_idx)) |=>
         ((alpha_sel == $past(wr_alpha)) && (beta_sel == $past(wr_beta)))
         || !$stable(rd_idx)); // R8

endmodule

// File: rtl/sc_lane.sv
module sc_lane #(
   parameter int SW    = 5,
   parameter int EXT_W = 6,
   parameter int WW    = 4,
   parameter int FRAC  = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld,
   input  logic [SW-1:0] chan,
   input  logic [EXT_W-1:0] ext,
   input  logic [WW-1:0] alpha,
   output logic [SW-1:0] out_q
);

   localparam int PW   = EXT_W + WW + 1;
   localparam int SUMW = PW + 1;
   localparam int SMAX = soft_comb_pkg::sym_limit(SW);
   localparam logic signed [PW-1:0]   BIAS   = PW'((1 << FRAC) - 1);
   localparam logic signed [SUMW-1:0] LIM_HI = SUMW'(SMAX);
   localparam logic signed [SUMW-1:0] LIM_LO = -SUMW'(SMAX);

   logic signed [PW-1:0]   prod;
   logic signed [PW-1:0]   adj;
   logic signed [PW-1:0]   scaled;
   logic signed [SUMW-1:0] sum;
   logic [SW-1:0]          sat;

   // Signed extrinsic times unsigned weight; truncate toward zero.
   always_comb begin
      prod   = $signed({{(PW-EXT_W){ext[EXT_W-1]}}, ext})
             * $signed({{(PW-WW){1'b0}}, alpha});
      adj    = prod[PW-1] ? (prod + BIAS) : prod;
      scaled = adj >>> FRAC;
   end

   always_comb begin
      sum = $signed({{(SUMW-SW){chan[SW-1]}}, chan})
          + $signed({scaled[PW-1], scaled});
      if (sum > LIM_HI)      sat = LIM_HI[SW-1:0];
      else if (sum < LIM_LO) sat = LIM_LO[SW-1:0];
      else                   sat = sum[SW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   out_q <= '0;
      else if (vld) out_q <= sat;
   end

   AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (int'($signed(out_q)) <= SMAX) && (int'($signed(out_q)) >= -SMAX)); // R5

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !chan[SW-1] && !scaled[PW-1]) |=> !out_q[SW-1]); // R5

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && chan[SW-1] && scaled[PW-1]) |=> out_q[SW-1]); // R5

endmodule

// File: rtl/soft_combiner.sv
module soft_combiner #(
   parameter int LANES = 4,
   parameter int SW    = 5,
   parameter int EXT_W = 6,
   parameter int LAT   = 16,
   parameter int WW    = 4,
   parameter int FRAC  = 3,
   parameter int BW    = 4,
   parameter int IDX_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [LANES*SW-1:0]    in_chan,
   input  logic [LANES*EXT_W-1:0] ext_soft,
   input  logic [IDX_W-1:0]       half_idx,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       wr_addr,
   input  logic [WW-1:0]          wr_alpha,
   input  logic [BW-1:0]          wr_beta,
   output logic [BW-1:0]          beta_sel,
   output logic                   out_valid,
   output logic [LANES*SW-1:0]    out_soft
);

   localparam int CW        = LANES * SW;
   localparam int ALPHA_ONE = 1 << FRAC;

   generate
      if (!soft_comb_pkg::lanes_legal(LANES)) begin : g_bad_lanes
         $error("soft_combiner: LANES must be 1, 2, 4 or 8");
      end
      if (WW <= FRAC) begin : g_bad_weight
         $error("soft_combiner: weight width must exceed its fraction bits");
      end
      if (SW < 2 || EXT_W < 2) begin : g_bad_width
         $error("soft_combiner: soft widths must be at least 2 bits");
      end
      if (LAT < 0) begin : g_bad_lat
         $error("soft_combiner: LAT must not be negative");
      end
   endgenerate

   logic          al_vld;
   logic [CW-1:0] al_chan;
   logic [WW-1:0] alpha_sel;

   sc_delay_line #(.W(CW), .DEPTH(LAT)) u_delay (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (in_valid),
      .in_data  (in_chan),
      .out_vld  (al_vld),
      .out_data (al_chan)
   );

   sc_weight_table #(
      .IDX_W(IDX_W), .WW(WW), .BW(BW), .ALPHA_RST(ALPHA_ONE), .BETA_RST(0)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_alpha  (wr_alpha),
      .wr_beta   (wr_beta),
      .rd_idx    (half_idx),
      .alpha_sel (alpha_sel),
      .beta_sel  (beta_sel)
   );

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         sc_lane #(.SW(SW), .EXT_W(EXT_W), .WW(WW), .FRAC(FRAC)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .vld   (al_vld),
            .chan  (al_chan[k*SW +: SW]),
            .ext   (ext_soft[k*EXT_W +: EXT_W]),
            .alpha (alpha_sel),
            .out_q (out_soft[k*SW +: SW])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= al_vld;
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_soft)); // R10

endmodule

// File: tb/tb_soft_combiner.sv
module tb_soft_combiner;

   localparam int N  = 2;
   localparam int SW = 5;
   localparam int EW = 6;
   localparam int L  = 3;
   localparam int WW = 4;
   localparam int BW = 4;
   localparam int IW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [N*SW-1:0] in_chan = '0;
   logic [N*EW-1:0] ext_soft = '0;
   logic [IW-1:0] half_idx = '0;
   logic wr_en = 1'b0;
   logic [IW-1:0] wr_addr = '0;
   logic [WW-1:0] wr_alpha = '0;
   logic [BW-1:0] wr_beta = '0;
   logic [BW-1:0] beta_sel;
   logic out_valid;
   logic [N*SW-1:0] out_soft;

   soft_combiner #(
      .LANES(N), .SW(SW), .EXT_W(EW), .LAT(L), .WW(WW), .FRAC(3), .BW(BW), .IDX_W(IW)
   ) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
      .ext_soft(ext_soft), .half_idx(half_idx), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_alpha(wr_alpha), .wr_beta(wr_beta), .beta_sel(beta_sel),
      .out_valid(out_valid), .out_soft(out_soft)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   int alpha_m [16];
   int beta_m  [16];
   bit rv [16];
   int rc [16][N];
   int re [16][N];
   int ri [16];
   int exp_v = 0;
   int exp_d [N];
   int ch_g [N];
   int ex_g [N];
   string tag_g = "R3";

   task automatic check_int(input string tag, input int got, input int expv);
      checks++;
      if (got !== expv) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, expv, cyc);
      end
   endtask

   function automatic int model(input int ch, input int ex, input int w);
      int s;
      s = ch + (ex * w) / 8;
      if (s > 15) s = 15;
      if (s < -15) s = -15;
      return s;
   endfunction

   // Called at a falling edge: check the outputs, drive one cycle of inputs.
   task automatic step(input bit v, input int idx);
      int slot;
      int old;
      check_int("R2", int'(out_valid), exp_v);
      for (int l = 0; l < N; l++)
         check_int(tag_g, int'($signed(out_soft[l*SW +: SW])), exp_d[l]);
      slot = cyc % 16;
      old  = (cyc + 16 - L) % 16;
      rv[slot] = v;
      ri[slot] = idx;
      for (int l = 0; l < N; l++) begin
         rc[slot][l] = ch_g[l];
         re[slot][l] = ex_g[l];
      end
      in_valid = v;
      for (int l = 0; l < N; l++) in_chan[l*SW +: SW] = ch_g[l][SW-1:0];
      half_idx = ri[old][IW-1:0];
      for (int l = 0; l < N; l++) ext_soft[l*EW +: EW] = re[old][l][EW-1:0];
      exp_v = int'(rv[old]);
      if (rv[old])
         for (int l = 0; l < N; l++)
            exp_d[l] = model(rc[old][l], re[old][l], alpha_m[ri[old]]);
      @(posedge clk);
      @(negedge clk);
      cyc++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         for (int l = 0; l < N; l++) begin ch_g[l] = 0; ex_g[l] = 0; end
         step(1'b0, 0);
      end
   endtask

   task automatic write_entry(input int a, input int w, input int b);
      wr_en = 1'b1;
      wr_addr = a[IW-1:0];
      wr_alpha = w[WW-1:0];
      wr_beta = b[BW-1:0];
      idle(1);
      wr_en = 1'b0;
      alpha_m[a] = w;
      beta_m[a] = b;
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin
         alpha_m[i] = 8; beta_m[i] = 0; rv[i] = 1'b0; ri[i] = 0;
         for (int l = 0; l < N; l++) begin rc[i][l] = 0; re[i][l] = 0; end
      end
      for (int l = 0; l < N; l++) begin exp_d[l] = 0; ch_g[l] = 0; ex_g[l] = 0; end

      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: outputs during reset
      check_int("R1", int'(out_valid), 0);
      check_int("R1", int'(out_soft), 0);
      rst_n = 1'b1;
      // R1 R9: side constants after reset, read combinationally
      for (int i = 0; i < 16; i++) begin
         half_idx = i[IW-1:0];
         #1;
         check_int("R1 R9", int'(beta_sel), 0);
      end
      tag_g = "R1";
      idle(2);

      // Reset weight (1.0) on entry 0, full sweep, lanes paired differently (R6)
      tag_g = "R1 R3 R6";
      for (int c = -16; c < 16; c++)
         for (int e = -32; e < 32; e++) begin
            ch_g[0] = c;      ex_g[0] = e;
            ch_g[1] = -1 - c; ex_g[1] = -1 - e;
            step(1'b1, 0);
         end
      idle(L + 2);

      // R8: load every entry, weight = index, side constant = 15 - index
      for (int a = 0; a < 16; a++) write_entry(a, a, 15 - a);
      for (int a = 0; a < 16; a++) begin
         half_idx = a[IW-1:0];
         #1;
         check_int("R8 R9", int'(beta_sel), 15 - a);
      end

      // R4 R5 R7: every weight over every channel/extrinsic pair
      tag_g = "R3 R4 R5 R7";
      for (int a = 0; a < 16; a++)
         for (int c = -16; c < 16; c++)
            for (int e = -32; e < 32; e += 2) begin
               ch_g[0] = c; ex_g[0] = e;
               ch_g[1] = c; ex_g[1] = e + 1;
               step(1'b1, a);
            end
      idle(L + 2);

      // R7: index changes every cycle; R10 R2: gapped stream holds output
      tag_g = "R7 R10";
      for (int i = 0; i < 400; i++) begin
         for (int l = 0; l < N; l++) begin
            ch_g[l] = ((i * 7 + l * 3) % 32) - 16;
            ex_g[l] = ((i * 13 + l * 5) % 64) - 32;
         end
         step((i % 3) != 0, i % 16);
      end
      idle(L + 3);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule